// File: doc/BRIEF.md
# Comparator Output Conditioning with Gated Event Timer

This block sits between a pair of analog comparators and the digital fabric. Each comparator's asynchronous result goes through a per-lane inversion option and a per-lane enable. When a lane is switched off, its conditioned value is 0. The conditioned value can replace the normal GPIO data on that lane's pin. The pin's tri-state control keeps deciding whether the pin drives in either case. A read-only status vector holds every conditioned result at once, so software can sample both lanes together.

The last comparator lane can feed the gate of an event timer. As an option, that lane is captured on the falling edge of the prescaled timer clock, which arrives as an input. The timer advances on the rising edge of that clock. Because the two actions sit on opposite edges, the timer never samples a gate that is changing on its own counting edge. A select bit picks either an external gate pin or the captured comparator as the timer gate. The timer clock is brought into the system clock domain through a synchronizer, and both of its edges become one-cycle enables.

Configuration is loaded through a write strobe and cleared by reset.

Top module: `cmp_cond_gate`

## Requirements
- R1: For lane i, the conditioned output is `cmp_raw[i] XOR cfg_inv[i]` while `cfg_on[i]` is 1, and is 0 while `cfg_on[i]` is 0.
- R2: `pin_data[i]` equals lane i's conditioned output, combinationally and without synchronization, while `cfg_pin_sel[i]` is 1. It equals `gpio_out[i]` while `cfg_pin_sel[i]` is 0.
- R3: `pin_oe[i]` is the inverse of `pin_tris[i]`, whatever `cfg_pin_sel[i]` is.
- R4: `status[i]` mirrors lane i's conditioned output, with bit i belonging to lane i. All lanes can be read in the same cycle. No input writes this vector.
- R5: While `cfg_sync` is 0, the last lane's conditioned output reaches `status[NUM_CMP-1]` and the comparator gate source combinationally.
- R6: While `cfg_sync` is 1, the last lane's value is captured once for each falling edge of `tmr_clk`. After `SYNC_STAGES+1` system clock edges the captured value is visible on `status[NUM_CMP-1]`, and it holds between falling edges.
- R7: While `cfg_gate_sel` is 0, the timer gate is `ext_gate`. While it is 1, the gate is the last lane's value as defined in R5 and R6. The gate is active-high.
- R8: `count` rises by one for each rising edge of `tmr_clk` while `cfg_tmr_en` is 1 and the gate is high. The new value appears `SYNC_STAGES+1` system clock edges after the rise. In every other case `count` holds.
- R9: `count` wraps from all ones to 0. `tmr_ovf` is high for exactly one cycle, in the same cycle that `count` becomes 0.
- R10: After reset, every configuration bit is 0 and `count`, `status` and `tmr_ovf` are 0. `pin_data` then follows `gpio_out`.
- R11: Configuration inputs take effect on the system clock edge at which `cfg_we` is sampled high. They are ignored while `cfg_we` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmp_raw | input | NUM_CMP | Asynchronous comparator results |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_on | input | NUM_CMP | Per-lane comparator enable |
| cfg_inv | input | NUM_CMP | Per-lane polarity inversion |
| cfg_pin_sel | input | NUM_CMP | Per-lane pin mux select (1 = comparator) |
| cfg_sync | input | 1 | Capture last lane on timer clock falling edge |
| cfg_gate_sel | input | 1 | Timer gate source (0 = pin, 1 = comparator) |
| cfg_tmr_en | input | 1 | Timer enable |
| gpio_out | input | NUM_CMP | Normal GPIO pin data |
| pin_tris | input | NUM_CMP | Pin tri-state control (1 = high impedance) |
| ext_gate | input | 1 | External timer gate pin |
| tmr_clk | input | 1 | Prescaled timer clock |
| pin_data | output | NUM_CMP | Pin data after mux |
| pin_oe | output | NUM_CMP | Pin output enable |
| status | output | NUM_CMP | Read-only mirror of all conditioned outputs |
| count | output | TMR_W | Timer value |
| tmr_ovf | output | 1 | One-cycle wrap pulse |

## Verification
The bench builds the block with NUM_CMP=2, SYNC_STAGES=2 and TMR_W=8. The narrower counter brings the all-ones-to-zero wrap and its overflow pulse within a few thousand cycles. The 2-stage synchronizer fixes the latency from a timer clock edge to its effect at three system clocks. The bench can then place the comparator changes well inside a timer clock phase, which separates capture-on-falling-edge from pass-through behaviour.

// File: rtl/cmpg_pkg.sv
package cmpg_pkg;

    typedef enum logic {
        GSRC_PIN = 1'b0,
        GSRC_CMP = 1'b1
    } gate_src_e;

    typedef struct packed {
        logic      sync;
        gate_src_e gsel;
        logic      tmr_en;
    } tcfg_t;

endpackage

// File: rtl/cmpg_edge_det.sv
module cmpg_edge_det #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_in,
    output logic rise,
    output logic fall
);

    typedef struct packed {
        logic [STAGES-1:0] sh;
        logic              prev;
    } st_t;

    st_t st_q, st_d;

    always_comb begin
        st_d      = st_q;
        st_d.sh   = {st_q.sh[STAGES-2:0], async_in};
        st_d.prev = st_q.sh[STAGES-1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign rise = st_q.sh[STAGES-1] & ~st_q.prev;
    assign fall = ~st_q.sh[STAGES-1] & st_q.prev;

endmodule

// File: rtl/cmpg_pin_lane.sv
module cmpg_pin_lane (
    input  logic raw,
    input  logic on,
    input  logic inv,
    input  logic pin_sel,
    input  logic gpio,
    input  logic tris,
    output logic cond,
    output logic pin_data,
    output logic pin_oe
);

    always_comb begin
        cond     = on ? (raw ^ inv) : 1'b0;
        pin_data = pin_sel ? cond : gpio;
        pin_oe   = ~tris;
    end

endmodule

// File: rtl/cmpg_gate_timer.sv
module cmpg_gate_timer #(
    parameter int TMR_W = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               rise,
    input  logic               fall,
    input  logic               cmp_in,
    input  logic               ext_gate,
    input  cmpg_pkg::tcfg_t    tcfg,
    output logic               cmp_view,
    output logic               gate,
    output logic [TMR_W-1:0]   count,
    output logic               ovf
);

    typedef struct packed {
        logic             held;
        logic [TMR_W-1:0] cnt;
        logic             ovf;
    } st_t;

    st_t  st_q, st_d;
    logic step;

    always_comb begin
        cmp_view = tcfg.sync ? st_q.held : cmp_in;
        gate     = (tcfg.gsel == cmpg_pkg::GSRC_CMP) ? cmp_view : ext_gate;
        step     = rise & tcfg.tmr_en & gate;

        st_d     = st_q;
        st_d.ovf = 1'b0;
        if (fall) st_d.held = cmp_in;
        if (step) begin
            st_d.cnt = st_q.cnt + 1'b1;
            st_d.ovf = &st_q.cnt;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign count = st_q.cnt;
    assign ovf   = st_q.ovf;

endmodule

// File: rtl/cmp_cond_gate.sv
module cmp_cond_gate #(
    parameter int NUM_CMP     = 2,
    parameter int SYNC_STAGES = 2,
    parameter int TMR_W       = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_CMP-1:0] cmp_raw,
    input  logic               cfg_we,
    input  logic [NUM_CMP-1:0] cfg_on,
    input  logic [NUM_CMP-1:0] cfg_inv,
    input  logic [NUM_CMP-1:0] cfg_pin_sel,
    input  logic               cfg_sync,
    input  logic               cfg_gate_sel,
    input  logic               cfg_tmr_en,
    input  logic [NUM_CMP-1:0] gpio_out,
    input  logic [NUM_CMP-1:0] pin_tris,
    input  logic               ext_gate,
    input  logic               tmr_clk,
    output logic [NUM_CMP-1:0] pin_data,
    output logic [NUM_CMP-1:0] pin_oe,
    output logic [NUM_CMP-1:0] status,
    output logic [TMR_W-1:0]   count,
    output logic               tmr_ovf
);

    localparam int GATE_LANE = NUM_CMP - 1;

    typedef struct packed {
        logic [NUM_CMP-1:0] on;
        logic [NUM_CMP-1:0] inv;
        logic [NUM_CMP-1:0] pin_sel;
        cmpg_pkg::tcfg_t    t;
    } cfg_t;

    cfg_t cfg_q, cfg_d;

    logic [NUM_CMP-1:0] cond_w;
    logic               rise_w, fall_w, gate_w, gated_view_w;

    always_comb begin
        cfg_d = cfg_q;
        if (cfg_we) begin
            cfg_d.on       = cfg_on;
            cfg_d.inv      = cfg_inv;
            cfg_d.pin_sel  = cfg_pin_sel;
            cfg_d.t.sync   = cfg_sync;
            cfg_d.t.gsel   = cmpg_pkg::gate_src_e'(cfg_gate_sel);
            cfg_d.t.tmr_en = cfg_tmr_en;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cfg_q <= '0;
        else        cfg_q <= cfg_d;
    end

    for (genvar i = 0; i < NUM_CMP; i++) begin : g_lane
        cmpg_pin_lane u_lane (
            .raw      (cmp_raw[i]),
            .on       (cfg_q.on[i]),
            .inv      (cfg_q.inv[i]),
            .pin_sel  (cfg_q.pin_sel[i]),
            .gpio     (gpio_out[i]),
            .tris     (pin_tris[i]),
            .cond     (cond_w[i]),
            .pin_data (pin_data[i]),
            .pin_oe   (pin_oe[i])
        );
        if (i == GATE_LANE) begin : g_gated
            assign status[i] = gated_view_w;
        end else begin : g_plain
            assign status[i] = cond_w[i];
        end
    end

    cmpg_edge_det #(.STAGES(SYNC_STAGES)) u_edge (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (tmr_clk),
        .rise     (rise_w),
        .fall     (fall_w)
    );

    cmpg_gate_timer #(.TMR_W(TMR_W)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .rise     (rise_w),
        .fall     (fall_w),
        .cmp_in   (cond_w[GATE_LANE]),
        .ext_gate (ext_gate),
        .tcfg     (cfg_q.t),
        .cmp_view (gated_view_w),
        .gate     (gate_w),
        .count    (count),
        .ovf      (tmr_ovf)
    );

endmodule

// File: rtl/cmpg_chk.sv
module cmpg_chk #(
    parameter int TMR_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             rise,
    input logic             fall,
    input logic             gate,
    input logic             tmr_en,
    input logic             sync,
    input logic             view_g,
    input logic [TMR_W-1:0] count,
    input logic             ovf
);

    assert_count_step_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (rise && tmr_en && gate) |=> (count == TMR_W'($past(count) + 1'b1)));

    assert_count_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !(rise && tmr_en && gate) |=> $stable(count));

    assert_ovf_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
        ovf |-> (count == '0));

    assert_ovf_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
        ovf |=> !ovf);

    assert_sync_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (sync && !fall) |=> (!sync || $stable(view_g)));

    assert_edges_excl_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !(rise && fall));

endmodule

bind cmp_cond_gate cmpg_chk #(.TMR_W(TMR_W)) u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .rise   (rise_w),
    .fall   (fall_w),
    .gate   (gate_w),
    .tmr_en (cfg_q.t.tmr_en),
    .sync   (cfg_q.t.sync),
    .view_g (gated_view_w),
    .count  (count),
    .ovf    (tmr_ovf)
);

// File: tb/cmp_cond_gate_bench.sv
module cmp_cond_gate_bench;

    localparam int N = 2;
    localparam int W = 8;
    localparam int S = 2;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [N-1:0] cmp_raw = '0, cfg_on = '0, cfg_inv = '0, cfg_pin_sel = '0;
    logic [N-1:0] gpio_out = '0, pin_tris = '0;
    logic cfg_we = 0, cfg_sync = 0, cfg_gate_sel = 0, cfg_tmr_en = 0;
    logic ext_gate = 0, tmr_clk = 0;
    logic [N-1:0] pin_data, pin_oe, status;
    logic [W-1:0] count;
    logic tmr_ovf;

    int checks = 0, fails = 0;
    int exp_cnt = 0;

    always #2.5 clk = ~clk;

    cmp_cond_gate #(.NUM_CMP(N), .SYNC_STAGES(S), .TMR_W(W)) u_cmp_cond_gate (
        .clk(clk), .rst_n(rst_n), .cmp_raw(cmp_raw), .cfg_we(cfg_we),
        .cfg_on(cfg_on), .cfg_inv(cfg_inv), .cfg_pin_sel(cfg_pin_sel),
        .cfg_sync(cfg_sync), .cfg_gate_sel(cfg_gate_sel), .cfg_tmr_en(cfg_tmr_en),
        .gpio_out(gpio_out), .pin_tris(pin_tris), .ext_gate(ext_gate),
        .tmr_clk(tmr_clk), .pin_data(pin_data), .pin_oe(pin_oe),
        .status(status), .count(count), .tmr_ovf(tmr_ovf)
    );

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wr_cfg(input logic [N-1:0] on, input logic [N-1:0] inv,
                          input logic [N-1:0] sel, input logic sy,
                          input logic gs, input logic te);
        cfg_on = on; cfg_inv = inv; cfg_pin_sel = sel;
        cfg_sync = sy; cfg_gate_sel = gs; cfg_tmr_en = te;
        cfg_we = 1'b1;
        tick(1);
        cfg_we = 1'b0;
    endtask

    // one full timer clock period: high 4, low 4 system clocks
    task automatic tpulse();
        tmr_clk = 1'b1; tick(4);
        tmr_clk = 1'b0; tick(4);
    endtask

    task automatic t_reset();
        gpio_out = 2'b10; pin_tris = 2'b01;
        tick(1);
        chk("R10 count", int'(count), 0);
        chk("R10 status", int'(status), 0);
        chk("R10 ovf", int'(tmr_ovf), 0);
        chk("R10 pin follows gpio", int'(pin_data), 2);
        chk("R3 oe at reset", int'(pin_oe), 2);
    endtask

    task automatic t_cfg_and_polarity();
        cmp_raw = 2'b00;
        // strobe low: ignored
        cfg_on = 2'b11; cfg_inv = 2'b01; cfg_pin_sel = 2'b11;
        tick(2);
        chk("R11 ignored without strobe", int'(status), 0);
        chk("R11 pin unchanged", int'(pin_data), 2);
        wr_cfg(2'b11, 2'b01, 2'b11, 1'b0, 1'b0, 1'b0);
        chk("R1 inv lane0 raw0", int'(status), 1);
        chk("R2 pin from comparators", int'(pin_data), 1);
        cmp_raw = 2'b11; #1;
        chk("R1 raw11 inv01", int'(status), 2);
        chk("R2 pin unsynchronized", int'(pin_data), 2);
        chk("R4 mirror both lanes", int'(status), 2);
        wr_cfg(2'b01, 2'b01, 2'b10, 1'b0, 1'b0, 1'b0);
        chk("R1 lane1 off reads 0", int'(status), 0);
        chk("R2 lane0 gpio lane1 off", int'(pin_data), 0);
    endtask

    task automatic t_tris();
        wr_cfg(2'b11, 2'b00, 2'b11, 1'b0, 1'b0, 1'b0);
        pin_tris = 2'b10; #1;
        chk("R3 oe comparator mode", int'(pin_oe), 1);
        wr_cfg(2'b11, 2'b00, 2'b00, 1'b0, 1'b0, 1'b0);
        pin_tris = 2'b01; #1;
        chk("R3 oe gpio mode", int'(pin_oe), 2);
    endtask

    task automatic t_sync_off();
        wr_cfg(2'b11, 2'b00, 2'b00, 1'b0, 1'b0, 1'b0);
        cmp_raw = 2'b00; #1;
        chk("R5 pass-through low", int'(status[1]), 0);
        cmp_raw = 2'b10; #1;
        chk("R5 pass-through high", int'(status[1]), 1);
    endtask

    task automatic t_sync_on();
        cmp_raw = 2'b10;
        wr_cfg(2'b11, 2'b00, 2'b00, 1'b1, 1'b0, 1'b0);
        tpulse();
        chk("R6 captured 1 at fall", int'(status[1]), 1);
        cmp_raw = 2'b00; tick(2);
        chk("R6 hold while low phase", int'(status[1]), 1);
        tmr_clk = 1'b1; tick(4);
        chk("R6 hold across rise", int'(status[1]), 1);
        tmr_clk = 1'b0; tick(2);
        chk("R6 not yet before latency", int'(status[1]), 1);
        tick(1);
        chk("R6 captured 0 after fall", int'(status[1]), 0);
        tick(1);
    endtask

    task automatic t_gate_pin();
        wr_cfg(2'b11, 2'b00, 2'b00, 1'b0, 1'b0, 1'b1);
        ext_gate = 1'b0;
        tpulse(); tpulse();
        chk("R8 gate low holds", int'(count), exp_cnt);
        ext_gate = 1'b1;
        tmr_clk = 1'b1; tick(2);
        chk("R8 not before latency", int'(count), exp_cnt);
        tick(1);
        exp_cnt++;
        chk("R8 step after latency", int'(count), exp_cnt);
        tick(1); tmr_clk = 1'b0; tick(4);
        tpulse(); tpulse(); exp_cnt += 2;
        chk("R7 pin gate counts", int'(count), exp_cnt);
        wr_cfg(2'b11, 2'b00, 2'b00, 1'b0, 1'b0, 1'b0);
        tpulse(); tpulse();
        chk("R8 disabled holds", int'(count), exp_cnt);
    endtask

    task automatic t_gate_cmp();
        ext_gate = 1'b1;
        cmp_raw = 2'b00;
        wr_cfg(2'b11, 2'b00, 2'b00, 1'b0, 1'b1, 1'b1);
        tpulse(); tpulse();
        chk("R7 cmp gate low ignores pin", int'(count), exp_cnt);
        cmp_raw = 2'b10;
        tpulse(); tpulse(); tpulse(); exp_cnt += 3;
        chk("R7 cmp gate high counts", int'(count), exp_cnt);
        wr_cfg(2'b11, 2'b10, 2'b00, 1'b0, 1'b1, 1'b1);
        tpulse();
        chk("R7 inverted cmp gate holds", int'(count), exp_cnt);
    endtask

    task automatic t_wrap();
        ext_gate = 1'b1;
        wr_cfg(2'b11, 2'b00, 2'b00, 1'b0, 1'b0, 1'b1);
        while (exp_cnt < (1 << W) - 1) begin
            tpulse(); exp_cnt++;
        end
        chk("R9 at all ones", int'(count), (1 << W) - 1);
        chk("R9 no ovf yet", int'(tmr_ovf), 0);
        tmr_clk = 1'b1; tick(3);
        chk("R9 wrapped to 0", int'(count), 0);
        chk("R9 ovf pulse", int'(tmr_ovf), 1);
        tick(1);
        chk("R9 ovf one cycle", int'(tmr_ovf), 0);
        tmr_clk = 1'b0; tick(4);
        exp_cnt = 0;
    endtask

    initial begin
        tick(3);
        rst_n = 1'b1;
        t_reset();
        t_cfg_and_polarity();
        t_tris();
        t_sync_off();
        t_sync_on();
        t_gate_pin();
        t_gate_cmp();
        t_wrap();
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

endmodule